// File: doc/BRIEF.md
# Switch Reset Sequencing Controller

This block takes the board reset, a halt strap, a mode strap and a set of internal hot-reset requests, and produces the reset enables for the domains of a packet switch. The domains are the management bus engines, the switch core, and the upstream port's register bank, which is split into a sticky half and a non-sticky half. The block also issues a load request to an external EEPROM engine. A fundamental reset clears every domain, including the sticky fields. It then moves through an optional EEPROM-load phase and an optional halt phase before normal operation begins. In the halt phase the management buses and the port registers are already out of reset, so software can inspect and program the part while the core stays held. A control bit written by software ends the halt.

Once the block is running, each hot-reset request is routed by its kind to a subset of the domains. Sticky fields and the management buses never see a hot reset. The EEPROM engine and the management bus protocol sit outside the block. They reach it only through a done pulse and a halt-clear pulse.

Top module: `swrst_seq`

## Requirements
- R1: While `board_rst_n` is low, `mgmt_rst`, `port_sticky_rst`, `port_nonsticky_rst` and `core_rst` are 1, and `core_flush`, `eep_load_req`, `halted` and `running` are 0. These values appear without waiting for a clock edge.
- R2: The mode and halt straps are captured only while the release of `board_rst_n` passes through the synchronizer. `mode_q` shows the captured mode, and strap changes made later have no effect until the next board reset.
- R3: A mode strap value above 5 is reserved. It sets `mode_err` to 1, sets `mode_q` to 0 (transparent), and never produces an EEPROM load.
- R4: Mode values 1, 3 and 5 (bit 0 set) select EEPROM initialization. After the reset phase, `eep_load_req` stays at 1 until `eep_done` is seen. During that time `mgmt_rst` and both port register resets are 0 and `core_rst` is 1. The other modes never raise `eep_load_req`.
- R5: If the captured halt strap is 1, the sequence stops in a halted phase with `halted` = 1, `core_rst` = 1, and the management and port register resets at 0. This phase follows the EEPROM load when one is required. A one-cycle `halt_clr` pulse moves the block to running.
- R6: `halt_clr` has no effect outside the halted phase, including a pulse given during the EEPROM load.
- R7: When running, `running` = 1 and all domain resets are 0 unless a hot reset applies. Only a board reset leaves this phase.
- R8: A whole-device hot request (`hot_req` bit 0) drives `core_rst` and `port_nonsticky_rst` to 1 from the next clock edge for as long as it is held. `mgmt_rst`, `port_sticky_rst` and `eep_load_req` stay 0.
- R9: A downstream-only hot request (`hot_req` bit 1) raises only `core_flush` while held. The core is not reset. If bit 0 is held at the same time, bit 0 wins and `core_flush` stays 0.
- R10: A local hot request (bit 2) or an external bridge request (bit 3) changes none of the outputs.
- R11: Hot requests made before the running phase do not change `port_nonsticky_rst` or `core_flush`, and do not alter the sequence.
- R12: A board reset in any phase returns the block to R1 and repeats the whole sequence, including the EEPROM load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| board_rst_n | input | 1 | Board reset, active low, asynchronous assert |
| mode_strap | input | MODE_W | Operating-mode strap |
| halt_strap | input | 1 | Request to halt after reset |
| hot_req | input | 4 | Hot-reset requests by kind: 0 whole device, 1 downstream only, 2 local, 3 external bridge |
| eep_done | input | 1 | EEPROM engine completion pulse |
| halt_clr | input | 1 | Software clear of the halt bit (one-cycle pulse) |
| mgmt_rst | output | 1 | Reset for the management bus engines |
| port_sticky_rst | output | 1 | Reset for the sticky port register fields |
| port_nonsticky_rst | output | 1 | Reset for the non-sticky port register fields |
| core_rst | output | 1 | Full reset of the switch core |
| core_flush | output | 1 | Buffer flush of the switch core |
| eep_load_req | output | 1 | Request to the EEPROM engine |
| halted | output | 1 | Halted phase active |
| running | output | 1 | Normal operation |
| mode_q | output | MODE_W | Captured, validated mode |
| mode_err | output | 1 | Reserved mode strapped |

## Verification
The bench builds the block with a two-stage synchronizer, a three-cycle reset hold, and the full four-bit mode strap. With four bits, the reserved values 8 to 15 that come only from the upper bits can be reached as well as 6 and 7. The short hold leaves a gap of several cycles after capture while the block is still in reset, and strap changes made in that gap test that the capture is really frozen. The two-stage synchronizer keeps each reset sequence to a handful of cycles, so dozens of random strap, halt and hot-kind combinations fit into one run, along with directed board resets taken mid-operation.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_EEP   = 2'd1,
      ST_HALT  = 2'd2,
      ST_RUN   = 2'd3
   } seq_st_e;

   // hot request kinds (bit index in hot_req)
   localparam int HOT_N     = 4;
   localparam int HK_ALL    = 0;
   localparam int HK_DOWN   = 1;
   localparam int HK_LOCAL  = 2;
   localparam int HK_BRIDGE = 3;

   // effect vector bit positions
   localparam int EF_W     = 3;
   localparam int EF_CORE  = 0;
   localparam int EF_FLUSH = 1;
   localparam int EF_NS    = 2;

   localparam int MODE_LAST_VALID = 5;

   function automatic logic [EF_W-1:0] hot_effect(input int kind);
      logic [EF_W-1:0] e;
      e = '0;
      case (kind)
         HK_ALL:  begin e[EF_CORE] = 1'b1; e[EF_NS] = 1'b1; end
         HK_DOWN: e[EF_FLUSH] = 1'b1;
         default: e = '0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/swrst_sync.sv
module swrst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_ok
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= 1'b0;
            else         chain <= 1'b1;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= '0;
            else         chain <= {chain[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign rst_ok = chain[STAGES-1];
endmodule

// File: rtl/swrst_strap.sv
module swrst_strap import swrst_pkg::*; #(
   parameter int MODE_W = 4
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              cap,
   input  logic [MODE_W-1:0] mode_raw,
   input  logic              halt_raw,
   output logic [MODE_W-1:0] mode_q,
   output logic              mode_err,
   output logic              eep_mode,
   output logic              halt_req
);
   logic hi_zero;
   logic valid;

   generate
      if (MODE_W > 3) begin : g_wide
         assign hi_zero = ~|mode_raw[MODE_W-1:3];
      end else begin : g_narrow
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign valid = hi_zero && (int'(mode_raw[2:0]) <= MODE_LAST_VALID);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mode_q   <= '0;
         mode_err <= 1'b0;
         halt_req <= 1'b0;
      end else if (cap) begin
         mode_q   <= valid ? mode_raw : '0;
         mode_err <= ~valid;
         halt_req <= halt_raw;
      end
   end

   assign eep_mode = mode_q[0];
endmodule

// File: rtl/swrst_fsm.sv
module swrst_fsm import swrst_pkg::*; #(
   parameter int HOLD_CYC = 4
) (
   input  logic    clk,
   input  logic    arst_n,
   input  logic    rst_ok,
   input  logic    eep_mode,
   input  logic    halt_req,
   input  logic    eep_done,
   input  logic    halt_clr,
   output seq_st_e st_d,
   output logic    cap
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   seq_st_e        st_q;
   logic [CW-1:0]  cnt;
   logic           hold_done;

   assign hold_done = rst_ok && (cnt == CW'(HOLD_CYC - 1));
   assign cap       = (st_q == ST_RESET) && !rst_ok;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RESET: if (hold_done) st_d = eep_mode ? ST_EEP : (halt_req ? ST_HALT : ST_RUN);
         ST_EEP:   if (eep_done)  st_d = halt_req ? ST_HALT : ST_RUN;
         ST_HALT:  if (halt_clr)  st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q <= ST_RESET;
         cnt  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RESET && rst_ok && !hold_done) cnt <= cnt + 1'b1;
         else                                         cnt <= '0;
      end
   end
endmodule

// File: rtl/swrst_dom.sv
module swrst_dom import swrst_pkg::*; (
   input  logic             clk,
   input  logic             arst_n,
   input  seq_st_e          st_d,
   input  logic [HOT_N-1:0] hot_req,
   output logic             mgmt_rst,
   output logic             port_sticky_rst,
   output logic             port_nonsticky_rst,
   output logic             core_rst,
   output logic             core_flush,
   output logic             eep_load_req,
   output logic             halted,
   output logic             running
);
   logic [EF_W-1:0] eff;
   logic            run_d;
   logic            fund_d;

   always_comb begin
      eff = '0;
      for (int k = 0; k < HOT_N; k++) begin
         if (hot_req[k]) eff = eff | hot_effect(k);
      end
   end

   assign run_d  = (st_d == ST_RUN);
   assign fund_d = (st_d == ST_RESET);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mgmt_rst           <= 1'b1;
         port_sticky_rst    <= 1'b1;
         port_nonsticky_rst <= 1'b1;
         core_rst           <= 1'b1;
         core_flush         <= 1'b0;
         eep_load_req       <= 1'b0;
         halted             <= 1'b0;
         running            <= 1'b0;
      end else begin
         mgmt_rst           <= fund_d;
         port_sticky_rst    <= fund_d;
         port_nonsticky_rst <= fund_d || (run_d && eff[EF_NS]);
         core_rst           <= !run_d || eff[EF_CORE];
         core_flush         <= run_d && eff[EF_FLUSH] && !eff[EF_CORE];
         eep_load_req       <= (st_d == ST_EEP);
         halted             <= (st_d == ST_HALT);
         running            <= run_d;
      end
   end
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq import swrst_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 4,
   parameter int MODE_W      = 4
) (
   input  logic              clk,
   input  logic              board_rst_n,
   input  logic [MODE_W-1:0] mode_strap,
   input  logic              halt_strap,
   input  logic [HOT_N-1:0]  hot_req,
   input  logic              eep_done,
   input  logic              halt_clr,
   output logic              mgmt_rst,
   output logic              port_sticky_rst,
   output logic              port_nonsticky_rst,
   output logic              core_rst,
   output logic              core_flush,
   output logic              eep_load_req,
   output logic              halted,
   output logic              running,
   output logic [MODE_W-1:0] mode_q,
   output logic              mode_err
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("swrst_seq: SYNC_STAGES must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("swrst_seq: HOLD_CYC must be at least 1");
      end
      if (MODE_W < 3) begin : g_bad_mode
         $error("swrst_seq: MODE_W must be at least 3");
      end
   endgenerate

   logic    rst_ok;
   logic    cap;
   logic    eep_mode;
   logic    halt_req;
   seq_st_e st_d;

   swrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (board_rst_n),
      .rst_ok (rst_ok)
   );

   swrst_strap #(.MODE_W(MODE_W)) u_strap (
      .clk      (clk),
      .arst_n   (board_rst_n),
      .cap      (cap),
      .mode_raw (mode_strap),
      .halt_raw (halt_strap),
      .mode_q   (mode_q),
      .mode_err (mode_err),
      .eep_mode (eep_mode),
      .halt_req (halt_req)
   );

   swrst_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
      .clk      (clk),
      .arst_n   (board_rst_n),
      .rst_ok   (rst_ok),
      .eep_mode (eep_mode),
      .halt_req (halt_req),
      .eep_done (eep_done),
      .halt_clr (halt_clr),
      .st_d     (st_d),
      .cap      (cap)
   );

   swrst_dom u_dom (
      .clk                (clk),
      .arst_n             (board_rst_n),
      .st_d               (st_d),
      .hot_req            (hot_req),
      .mgmt_rst           (mgmt_rst),
      .port_sticky_rst    (port_sticky_rst),
      .port_nonsticky_rst (port_nonsticky_rst),
      .core_rst           (core_rst),
      .core_flush         (core_flush),
      .eep_load_req       (eep_load_req),
      .halted             (halted),
      .running            (running)
   );
endmodule

// File: rtl/swrst_seq_chk.sv
module swrst_seq_chk #(
   parameter int MODE_W = 4
) (
   input logic              clk,
   input logic              board_rst_n,
   input logic              halt_clr,
   input logic              mgmt_rst,
   input logic              port_sticky_rst,
   input logic              core_rst,
   input logic              core_flush,
   input logic              eep_load_req,
   input logic              halted,
   input logic              running,
   input logic [MODE_W-1:0] mode_q,
   input logic              mode_err
);
   p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!board_rst_n)
      !mgmt_rst |=> $stable(mode_q));

   p_err_fallback_r3: assert property (@(posedge clk) disable iff (!board_rst_n)
      mode_err |-> (mode_q == '0));

   p_eep_mode_r4: assert property (@(posedge clk) disable iff (!board_rst_n)
      eep_load_req |-> (mode_q[0] && !mode_err && core_rst && !mgmt_rst));

   p_halt_hold_r5: assert property (@(posedge clk) disable iff (!board_rst_n)
      (halted && !halt_clr) |=> halted);

   p_core_until_run_r7: assert property (@(posedge clk) disable iff (!board_rst_n)
      !running |-> core_rst);

   p_run_stays_r7: assert property (@(posedge clk) disable iff (!board_rst_n)
      running |=> running);

   p_run_halt_excl_r7: assert property (@(posedge clk) disable iff (!board_rst_n)
      $countones({running, halted, eep_load_req}) <= 1);

   p_mgmt_stays_r8: assert property (@(posedge clk) disable iff (!board_rst_n)
      !mgmt_rst |=> !mgmt_rst);

   p_sticky_stays_r8: assert property (@(posedge clk) disable iff (!board_rst_n)
      !port_sticky_rst |=> !port_sticky_rst);

   p_flush_excl_r9: assert property (@(posedge clk) disable iff (!board_rst_n)
      core_flush |-> (running && !core_rst));
endmodule

bind swrst_seq swrst_seq_chk #(.MODE_W(MODE_W)) u_chk (.*);

// File: tb/swrst_seq_tb.sv
module swrst_seq_tb;
   localparam int SS = 2;
   localparam int HC = 3;
   localparam int MW = 4;

   logic          clk = 1'b0;
   logic          board_rst_n = 1'b0;
   logic [MW-1:0] mode_strap = '0;
   logic          halt_strap = 1'b0;
   logic [3:0]    hot_req = '0;
   logic          eep_done = 1'b0;
   logic          halt_clr = 1'b0;
   logic mgmt_rst, port_sticky_rst, port_nonsticky_rst, core_rst, core_flush;
   logic eep_load_req, halted, running, mode_err;
   logic [MW-1:0] mode_q;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   swrst_seq #(.SYNC_STAGES(SS), .HOLD_CYC(HC), .MODE_W(MW)) u_dut (
      .clk(clk), .board_rst_n(board_rst_n), .mode_strap(mode_strap),
      .halt_strap(halt_strap), .hot_req(hot_req), .eep_done(eep_done),
      .halt_clr(halt_clr), .mgmt_rst(mgmt_rst), .port_sticky_rst(port_sticky_rst),
      .port_nonsticky_rst(port_nonsticky_rst), .core_rst(core_rst),
      .core_flush(core_flush), .eep_load_req(eep_load_req), .halted(halted),
      .running(running), .mode_q(mode_q), .mode_err(mode_err)
   );

   // {mgmt, sticky, nonsticky, core, flush, eep}
   function automatic logic [5:0] outv();
      return {mgmt_rst, port_sticky_rst, port_nonsticky_rst, core_rst, core_flush, eep_load_req};
   endfunction

   function automatic bit mode_ok(input int m);
      return m <= 5;
   endfunction

   function automatic logic [5:0] exp_hot(input logic [3:0] h);
      if (h[0])      return 6'b001100;
      else if (h[1]) return 6'b000010;
      else           return 6'b000000;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // board reset, release, then disturb the straps after capture
   task automatic board_cycle(input int m, input bit h);
      tick();
      board_rst_n = 1'b0;
      hot_req = '0; eep_done = 1'b0; halt_clr = 1'b0;
      mode_strap = MW'(m); halt_strap = h;
      #1;
      chk("R1 async outputs", int'({outv(), halted, running}), 8'b11110000);
      tick(); tick();
      board_rst_n = 1'b1;
      tick(); tick(); tick();
      mode_strap = ~MW'(m);
      halt_strap = ~h;
   endtask

   task automatic wait_exit();
      for (int i = 0; i < 40; i++) begin
         if (!mgmt_rst) break;
         tick();
      end
   endtask

   task automatic run_trial(input int m, input bit h, input int hk, input bit early_clr);
      bit       eep_exp;
      int       mexp;
      logic [3:0] hv;
      eep_exp = mode_ok(m) && (m % 2 == 1);
      mexp    = mode_ok(m) ? m : 0;
      board_cycle(m, h);
      wait_exit();
      chk("R2 mode_q captured at release", int'(mode_q), mexp);
      chk("R3 mode_err", int'(mode_err), mode_ok(m) ? 0 : 1);
      if (eep_exp) begin
         chk("R4 eeprom phase outputs", int'(outv()), 6'b000101);
         hot_req = 4'b0011;
         if (early_clr) halt_clr = 1'b1;
         tick();
         hot_req = '0; halt_clr = 1'b0;
         chk("R11 hot ignored in eeprom phase", int'(outv()), 6'b000101);
         tick();
         chk("R4 still loading without done", int'(eep_load_req), 1);
         eep_done = 1'b1;
         tick();
         eep_done = 1'b0;
         chk("R4 load released after done", int'(eep_load_req), 0);
      end else begin
         chk("R4 no load outside eeprom modes", int'(eep_load_req), 0);
      end
      if (h) begin
         chk("R6 halt survives early clear", int'(halted), 1);
         chk("R5 halted outputs", int'(outv()), 6'b000100);
         hot_req = 4'b0001;
         tick();
         hot_req = '0;
         chk("R11 hot ignored while halted", int'({outv(), halted}), 7'b0001001);
         tick(); tick();
         chk("R5 halt held", int'({halted, running}), 2'b10);
         halt_clr = 1'b1;
         tick();
         halt_clr = 1'b0;
      end
      chk("R7 running, domains released", int'({outv(), halted, running}), 8'b00000001);
      halt_clr = 1'b1;
      tick();
      halt_clr = 1'b0;
      chk("R6 clear ignored while running", int'({outv(), running}), 7'b0000001);
      hv = 4'(1 << hk);
      if (hk == 4) hv = 4'b0011;
      hot_req = hv;
      tick();
      chk((hk == 0) ? "R8 whole-device hot" : (hk == 1 || hk == 4) ? "R9 downstream hot" : "R10 local/bridge hot",
          int'(outv()), int'(exp_hot(hv)));
      tick();
      chk("R8 hot held", int'(outv()), int'(exp_hot(hv)));
      hot_req = '0;
      tick();
      chk("R7 released after hot", int'({outv(), running}), 7'b0000001);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL R12 watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0101));
      tick();
      chk("R1 reset state", int'({outv(), halted, running}), 8'b11110000);
      chk("R1 mode_q in reset", int'({mode_q, mode_err}), 0);
      // directed corners
      run_trial(1, 1'b1, 0, 1'b1);   // eeprom + halt + early clear
      run_trial(0, 1'b0, 1, 1'b0);
      run_trial(7, 1'b0, 2, 1'b0);   // reserved, low bits
      run_trial(12, 1'b1, 3, 1'b0);  // reserved via upper bits
      run_trial(5, 1'b0, 4, 1'b0);   // both global kinds together
      // R12: board reset in the middle of an eeprom load, then full sequence
      board_cycle(3, 1'b0);
      wait_exit();
      chk("R12 eeprom phase before abort", int'(eep_load_req), 1);
      run_trial(3, 1'b0, 0, 1'b0);
      // random mix
      for (int t = 0; t < 40; t++) begin
         run_trial(int'($urandom % 16), 1'($urandom % 2), int'($urandom % 5), 1'($urandom % 2));
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule